// File: doc/BRIEF.md
# Accumulator ALU with compare flag

This block is the combinational execute stage of a 16-bit accumulator machine. Each evaluation takes the present accumulator, one operand, a 4-bit operation code, a source selector and the incoming carry and flag bits. It returns the next accumulator, the next carry and the next compare flag. The surrounding core registers these three values and feeds them back on the next instruction.

The operand is a register value or an immediate field. When the source selector marks an immediate, the block widens the low bits itself. Shift operations take a 6-bit unsigned amount. All other operations take an 8-bit signed value. Add and subtract results go to the accumulator, and carry-in and carry-out let a wider number be processed in 16-bit pieces. Logic operations and shifts also write the accumulator. The three compares write only the single flag. A dedicated code inverts the flag.

Top module: `acc_alu_exec`

## Requirements
- R1: With op 0 (add) the accumulator becomes A + B modulo 2^16. With op 1 (add with carry) it becomes A + B + carry_in. In both cases carry_out is the bit-16 carry of the sum.
- R2: With op 2 (subtract) the accumulator becomes A - B modulo 2^16. With op 3 (subtract with borrow) it becomes A - B - carry_in. In both cases carry_out is 1 exactly when the true difference is negative.
- R3: Ops 4, 5 and 6 give A AND B, A OR B and A XOR B, and leave carry_out equal to carry_in.
- R4: When src_imm is 1 and the op is not a shift (ops 0-6 and 11-13), B is operand[7:0] sign-extended to 16 bits, and operand[15:8] has no effect. When src_imm is 0, B is the full operand.
- R5: Ops 7 and 9 shift A left and fill with zeros. Op 8 shifts A right and fills with A[15]. Op 10 shifts A right and fills with zeros. Carry is unchanged. The amount is operand[5:0] zero-extended when src_imm is 1, and the full 16-bit operand otherwise.
- R6: An amount of 16 or more gives 0 for ops 7, 9 and 10, and gives sixteen copies of A[15] for op 8.
- R7: Ops 11 (less), 12 (greater) and 13 (equal) compare A with B as signed two's-complement values. They set flag_out to 1 when the condition holds and to 0 otherwise. acc_out equals acc_in and carry_out equals carry_in.
- R8: Op 14 sets flag_out to the complement of flag_in and leaves accumulator and carry unchanged.
- R9: Ops 0-10 and op 15 leave flag_out equal to flag_in. Op 15 also passes the accumulator and carry through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_in | input | 16 | Present accumulator value |
| operand | input | 16 | Register value or raw immediate field |
| src_imm | input | 1 | 1 selects immediate widening of operand |
| op | input | 4 | Operation code (0-15) |
| carry_in | input | 1 | Present carry / borrow bit |
| flag_in | input | 1 | Present compare flag |
| acc_out | output | 16 | Next accumulator value |
| carry_out | output | 1 | Next carry / borrow bit |
| flag_out | output | 1 | Next compare flag |

## Verification
The accumulator result and the carry/borrow bit come from one sum in the same evaluation, so a mistake in either shows up as a mismatch between the two. The bench targets the boundaries where they meet: 0xFFFF plus 1 with and without carry-in, 0 minus 1 with borrow-in, and a negative immediate added to a small value. It compares both outputs with its own 17-bit integer model. It also drives compares with carry and flag set to values that the compare must keep, and it checks that the held fields still match their inputs.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int ACC_W   = 16;
  localparam int IMM_W   = 8;
  localparam int SHIMM_W = 6;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADC  = 4'd1,  OP_SUB  = 4'd2,  OP_SBB  = 4'd3,
    OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6,  OP_SLA  = 4'd7,
    OP_SRA  = 4'd8,  OP_SLL  = 4'd9,  OP_SRL  = 4'd10, OP_CLT  = 4'd11,
    OP_CGT  = 4'd12, OP_CEQ  = 4'd13, OP_FNOT = 4'd14, OP_NOP  = 4'd15
  } acc_op_e;

  typedef enum logic [1:0] {
    SH_LEFT = 2'd0, SH_RIGHT_LOG = 2'd1, SH_RIGHT_ARI = 2'd2
  } shift_kind_e;

  // Signed widening of a short immediate field
  function automatic logic [ACC_W-1:0] widen_signed(input logic [IMM_W-1:0] f);
    return {{(ACC_W-IMM_W){f[IMM_W-1]}}, f};
  endfunction

  // Unsigned widening of a shift-amount field
  function automatic logic [ACC_W-1:0] widen_unsigned(input logic [SHIMM_W-1:0] f);
    return {{(ACC_W-SHIMM_W){1'b0}}, f};
  endfunction

  // One-bit-wider add or subtract; top bit is carry or borrow
  function automatic logic [ACC_W:0] wide_addsub(input logic [ACC_W-1:0] a,
                                                 input logic [ACC_W-1:0] b,
                                                 input logic             cin,
                                                 input logic             sub);
    logic [ACC_W:0] ea, eb, ec;
    ea = {1'b0, a};
    eb = {1'b0, b};
    ec = {{ACC_W{1'b0}}, cin};
    return sub ? (ea - eb - ec) : (ea + eb + ec);
  endfunction
endpackage

// File: rtl/acc_addsub.sv
module acc_addsub
  import acc_alu_pkg::*;
#(
  parameter int W = ACC_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] wide;

  always_comb begin
    wide = wide_addsub(a, b, cin, sub);
    sum  = wide[W-1:0];
    cout = wide[W];
  end

  // Adding or subtracting zero with no carry-in cannot carry or borrow
  always_comb begin
    if (b == '0 && !cin) begin
      assert_zero_operand_R1: assert (sum == a && !cout)
        else $error("zero operand changed value or carried");
    end
  end
endmodule

// File: rtl/acc_shifter.sv
module acc_shifter
  import acc_alu_pkg::*;
#(
  parameter int W = ACC_W
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  amt,
  input  shift_kind_e   kind,
  output logic [W-1:0]  res
);
  localparam int STAGES = $clog2(W);

  logic             right;
  logic             fill;
  logic             over_range;
  logic [W-1:0]     stage [STAGES+1];

  assign right      = (kind != SH_LEFT);
  assign fill       = (kind == SH_RIGHT_ARI) ? a[W-1] : 1'b0;
  assign over_range = |amt[W-1:STAGES];
  assign stage[0]   = a;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int SH = 1 << k;
    logic [W-1:0] moved;
    assign moved = right ? {{SH{fill}}, stage[k][W-1:SH]}
                         : {stage[k][W-1-SH:0], {SH{1'b0}}};
    assign stage[k+1] = amt[k] ? moved : stage[k];
  end

  assign res = over_range ? {W{fill}} : stage[STAGES];

  // Saturated shifts produce only fill bits
  always_comb begin
    if (over_range) begin
      assert_saturate_R6: assert (res == {W{fill}})
        else $error("out-of-range shift left data bits");
    end
    if (amt == '0) begin
      assert_zero_shift_R5: assert (res == a)
        else $error("zero shift altered value");
    end
  end
endmodule

// File: rtl/acc_compare.sv
module acc_compare
  import acc_alu_pkg::*;
#(
  parameter int W = ACC_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         lt,
  output logic         gt,
  output logic         eq
);
  assign lt = $signed(a) < $signed(b);
  assign gt = $signed(a) > $signed(b);
  assign eq = (a == b);

  // Exactly one ordering relation holds
  always_comb begin
    assert_one_relation_R7: assert ($countones({lt, gt, eq}) == 1)
      else $error("compare relations not exclusive");
  end
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import acc_alu_pkg::*;
(
  input  logic [15:0] acc_in,
  input  logic [15:0] operand,
  input  logic        src_imm,
  input  logic [3:0]  op,
  input  logic        carry_in,
  input  logic        flag_in,
  output logic [15:0] acc_out,
  output logic        carry_out,
  output logic        flag_out
);
  acc_op_e      opc;
  logic         is_shift, is_cmp, is_arith, use_cin, is_sub;
  logic [15:0]  opnd;
  logic [15:0]  arith_sum;
  logic         arith_cout;
  logic [15:0]  shift_res;
  shift_kind_e  shift_kind;
  logic         cmp_lt, cmp_gt, cmp_eq;

  assign opc      = acc_op_e'(op);
  assign is_shift = (opc == OP_SLA) || (opc == OP_SRA) || (opc == OP_SLL) || (opc == OP_SRL);
  assign is_cmp   = (opc == OP_CLT) || (opc == OP_CGT) || (opc == OP_CEQ);
  assign is_arith = (opc == OP_ADD) || (opc == OP_ADC) || (opc == OP_SUB) || (opc == OP_SBB);
  assign use_cin  = (opc == OP_ADC) || (opc == OP_SBB);
  assign is_sub   = (opc == OP_SUB) || (opc == OP_SBB);

  always_comb begin
    if (!src_imm)      opnd = operand;
    else if (is_shift) opnd = widen_unsigned(operand[SHIMM_W-1:0]);
    else               opnd = widen_signed(operand[IMM_W-1:0]);
  end

  always_comb begin
    case (opc)
      OP_SRA:  shift_kind = SH_RIGHT_ARI;
      OP_SRL:  shift_kind = SH_RIGHT_LOG;
      default: shift_kind = SH_LEFT;
    endcase
  end

  acc_addsub #(.W(ACC_W)) u_addsub (
    .a    (acc_in),
    .b    (opnd),
    .cin  (use_cin & carry_in),
    .sub  (is_sub),
    .sum  (arith_sum),
    .cout (arith_cout)
  );

  acc_shifter #(.W(ACC_W)) u_shifter (
    .a    (acc_in),
    .amt  (opnd),
    .kind (shift_kind),
    .res  (shift_res)
  );

  acc_compare #(.W(ACC_W)) u_compare (
    .a  (acc_in),
    .b  (opnd),
    .lt (cmp_lt),
    .gt (cmp_gt),
    .eq (cmp_eq)
  );

  always_comb begin
    acc_out   = acc_in;
    carry_out = carry_in;
    flag_out  = flag_in;
    unique case (opc)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        acc_out   = arith_sum;
        carry_out = arith_cout;
      end
      OP_AND:  acc_out = acc_in & opnd;
      OP_OR:   acc_out = acc_in | opnd;
      OP_XOR:  acc_out = acc_in ^ opnd;
      OP_SLA, OP_SRA, OP_SLL, OP_SRL: acc_out = shift_res;
      OP_CLT:  flag_out = cmp_lt;
      OP_CGT:  flag_out = cmp_gt;
      OP_CEQ:  flag_out = cmp_eq;
      OP_FNOT: flag_out = ~flag_in;
      OP_NOP:  ;
    endcase
  end

  // Guards on which outputs each operation class may touch
  always_comb begin
    if (is_cmp || opc == OP_FNOT) begin
      assert_acc_hold_R7: assert (acc_out == acc_in && carry_out == carry_in)
        else $error("flag operation disturbed accumulator or carry");
    end
    if (!is_cmp && opc != OP_FNOT) begin
      assert_flag_hold_R9: assert (flag_out == flag_in)
        else $error("non-flag operation changed flag");
    end
    if (opc == OP_FNOT) begin
      assert_flag_flip_R8: assert (flag_out != flag_in)
        else $error("flag invert did not invert");
    end
    if (!is_arith) begin
      assert_carry_hold_R3: assert (carry_out == carry_in)
        else $error("carry changed outside add/subtract");
    end
  end
endmodule

// File: tb/acc_alu_exec_tb.sv
`timescale 1ns/1ps
module acc_alu_exec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] acc_in = '0;
  logic [15:0] operand = '0;
  logic        src_imm = 1'b0;
  logic [3:0]  op = 4'd15;
  logic        carry_in = 1'b0;
  logic        flag_in = 1'b0;
  logic [15:0] acc_out;
  logic        carry_out;
  logic        flag_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  acc_alu_exec u_dut (
    .acc_in    (acc_in),
    .operand   (operand),
    .src_imm   (src_imm),
    .op        (op),
    .carry_in  (carry_in),
    .flag_in   (flag_in),
    .acc_out   (acc_out),
    .carry_out (carry_out),
    .flag_out  (flag_out)
  );

  // Independent reference built from the requirement text
  task automatic model(input int o, input int a, input int b, input bit imm,
                       input bit ci, input bit fi,
                       output int ea, output bit ec, output bit ef);
    int v, n, t;
    ea = a; ec = ci; ef = fi;
    if (!imm) v = b;
    else if (o >= 7 && o <= 10) v = b % 64;
    else begin
      v = b % 256;
      if (v >= 128) v = v + 65280;
    end
    case (o)
      0, 1: begin
        t = a + v + ((o == 1) ? int'(ci) : 0);
        ea = t % 65536; ec = (t >= 65536);
      end
      2, 3: begin
        t = a - v - ((o == 3) ? int'(ci) : 0);
        ec = (t < 0); ea = (t + 131072) % 65536;
      end
      4: ea = a & v;
      5: ea = a | v;
      6: ea = a ^ v;
      7, 8, 9, 10: begin
        n = v;
        if (o == 8) begin
          t = (a >= 32768) ? a - 65536 : a;
          for (int i = 0; i < n && i < 16; i++) t = (t < 0) ? -((-t + 1) / 2) : t / 2;
          ea = (t + 65536) % 65536;
        end else if (o == 10) begin
          ea = (n >= 16) ? 0 : a / (1 << n);
        end else begin
          ea = (n >= 16) ? 0 : (a * (1 << n)) % 65536;
        end
      end
      11, 12, 13: begin
        int sa, sb;
        sa = (a >= 32768) ? a - 65536 : a;
        sb = (v >= 32768) ? v - 65536 : v;
        ef = (o == 11) ? (sa < sb) : (o == 12) ? (sa > sb) : (sa == sb);
      end
      14: ef = !fi;
      default: ;
    endcase
  endtask

  task automatic run_op(input int o, input int a, input int b, input bit imm,
                        input bit ci, input bit fi, input string tag);
    int ea; bit ec, ef;
    @(negedge clk);
    op = o[3:0]; acc_in = a[15:0]; operand = b[15:0];
    src_imm = imm; carry_in = ci; flag_in = fi;
    model(o, a, b, imm, ci, fi, ea, ec, ef);
    @(posedge clk); #1;
    n_run++;
    if (acc_out !== ea[15:0] || carry_out !== ec || flag_out !== ef) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%0b: got acc=%h c=%0b f=%0b exp acc=%h c=%0b f=%0b",
               tag, o, a[15:0], b[15:0], imm, acc_out, carry_out, flag_out,
               ea[15:0], ec, ef);
    end
  endtask

  task automatic t_idle();   // R9 pass-through after bench reset
    run_op(15, 16'h1234, 16'hFFFF, 0, 1, 1, "R9 idle");
    run_op(15, 0, 0, 1, 0, 0, "R9 idle");
  endtask

  task automatic t_add();
    run_op(0, 16'h0001, 16'h0002, 0, 1, 0, "R1 add ignores cin");
    run_op(0, 16'hFFFF, 16'h0001, 0, 0, 1, "R1 add carry out");
    run_op(1, 16'hFFFF, 16'h0000, 0, 1, 0, "R1 adc carry chain");
    run_op(1, 16'h7FFE, 16'h0001, 0, 1, 1, "R1 adc");
  endtask

  task automatic t_sub();
    run_op(2, 16'h0000, 16'h0001, 0, 0, 0, "R2 sub borrow");
    run_op(2, 16'h0005, 16'h0005, 0, 1, 1, "R2 sub zero");
    run_op(3, 16'h0000, 16'h0000, 0, 1, 0, "R2 sbb borrow in");
    run_op(3, 16'h8000, 16'h0001, 0, 0, 0, "R2 sbb");
  endtask

  task automatic t_logic();
    run_op(4, 16'hF0F0, 16'h3C3C, 0, 1, 0, "R3 and");
    run_op(5, 16'hF0F0, 16'h0F01, 0, 0, 1, "R3 or");
    run_op(6, 16'hAAAA, 16'hFFFF, 0, 1, 1, "R3 xor");
  endtask

  task automatic t_imm();
    run_op(0, 16'h0010, 16'hAB80, 1, 0, 0, "R4 addi negative");
    run_op(4, 16'h1234, 16'h00F0, 1, 0, 0, "R4 andi sign ext");
    run_op(6, 16'h1234, 16'h5A7F, 1, 0, 0, "R4 xori high ignored");
    run_op(11, 16'hFFFE, 16'h12FF, 1, 0, 0, "R4 cli negative");
  endtask

  task automatic t_shift();
    run_op(7, 16'h8421, 16'h0003, 0, 1, 0, "R5 sla");
    run_op(8, 16'h8420, 16'h0004, 0, 0, 1, "R5 sra sign fill");
    run_op(9, 16'h00FF, 16'hFFC4, 1, 0, 0, "R5 slli amount 4");
    run_op(10, 16'h8000, 16'h000F, 0, 1, 1, "R5 srl 15");
    run_op(8, 16'h4000, 16'h0000, 0, 0, 0, "R5 sra zero");
  endtask

  task automatic t_sat();
    run_op(9, 16'hFFFF, 16'h0010, 0, 0, 0, "R6 sll 16");
    run_op(10, 16'hFFFF, 16'h0100, 0, 0, 0, "R6 srl 256");
    run_op(8, 16'h8001, 16'h003F, 1, 0, 0, "R6 srai 63");
    run_op(8, 16'h7FFF, 16'h0020, 0, 0, 0, "R6 sra pos");
    run_op(7, 16'h0001, 16'h0011, 1, 1, 0, "R6 slai 17");
  endtask

  task automatic t_cmp();
    run_op(11, 16'hFFFF, 16'h0001, 0, 1, 0, "R7 lt signed");
    run_op(12, 16'hFFFF, 16'h0001, 0, 0, 1, "R7 gt signed");
    run_op(12, 16'h7FFF, 16'h8000, 0, 1, 0, "R7 gt extremes");
    run_op(13, 16'h5555, 16'h5555, 0, 0, 0, "R7 eq");
    run_op(13, 16'h5555, 16'h5554, 0, 1, 1, "R7 ne");
  endtask

  task automatic t_fnot();
    run_op(14, 16'hBEEF, 16'h1111, 0, 1, 0, "R8 flag invert 0");
    run_op(14, 16'hBEEF, 16'h1111, 1, 0, 1, "R8 flag invert 1");
  endtask

  task automatic t_hold();
    for (int o = 0; o < 11; o++) run_op(o, 16'h0F0F, 16'h0002, 0, 1, 1, "R9 flag kept");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_add();
    t_sub();
    t_logic();
    t_imm();
    t_shift();
    t_sat();
    t_cmp();
    t_fnot();
    t_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule